// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This block turns a 64-bit packed floating-point operand into two signed integer lanes, one pipeline register deep. A 2-bit mode input picks one of four conversions. Two are full-accuracy conversions, from single or double precision, that follow a programmable rounding direction and report invalid and inexact conditions for each lane. The other two are relaxed single-precision conversions that always chop toward zero and raise no flags: one gives a 32-bit integer, the other a saturated 16-bit integer widened by sign extension.

Single-precision modes read both lanes from the low source word. Double-precision mode reads lane 0 from the low source word and lane 1 from the high source word. A truncate input forces round-toward-zero in the full-accuracy modes, whatever the rounding-control field holds. Trapping, register storage and memory access belong to the surrounding pipeline.

Top module: `pfi_conv`

## Requirements
- R1: Mode encoding is 0 = single to int32 (full accuracy), 1 = single to int32 (relaxed), 2 = single to int16 (narrow), 3 = double to int32. In single modes lane k reads `src_lo_i[32k+31:32k]` and `src_hi_i` is ignored. In double mode lane 0 reads `src_lo_i` and lane 1 reads `src_hi_i`. Lane k is written to `result_o[32k+31:32k]`. Outputs appear one clock after the inputs and are all zero during reset.
- R2: In modes 0 and 3 with truncate low, `rc_i` chooses the rounding: 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero.
- R3: In modes 0 and 3 with truncate high, every inexact value is rounded toward zero, whatever `rc_i` holds.
- R4: In modes 0 and 3, a NaN, an infinity or a rounded value outside [-2^31, 2^31-1] gives 0x80000000 with invalid set and inexact clear. An exact -2^31 is valid.
- R5: In modes 0 and 3, inexact is set exactly when the source has a nonzero fraction and the lane is not invalid.
- R6: In modes 0 and 3, a subnormal source gives 0 with inexact set, except that it gives -1 for a negative source rounded toward minus infinity and +1 for a positive source rounded toward plus infinity. A zero of either sign gives 0 with no flags.
- R7: Mode 3 applies R2 to R6 to the two 64-bit double-precision lanes.
- R8: Mode 2 chops toward zero and saturates magnitudes beyond the 16-bit range to 0x7FFF or 0x8000, then sign-extends the result to 32 bits.
- R9: Mode 1 chops toward zero. A finite source outside the int32 range gives 0x80000000.
- R10: In modes 1 and 2, `rc_i` and `trunc_i` have no effect and both flags stay low. The result for NaN, infinity and subnormal sources is unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Conversion mode select |
| trunc_i | input | 1 | Force round toward zero in modes 0 and 3 |
| rc_i | input | 2 | Rounding direction for modes 0 and 3 |
| src_lo_i | input | 64 | Packed single lanes, or the lane-0 double |
| src_hi_i | input | 64 | Lane-1 double (mode 3 only) |
| result_o | output | 64 | Two 32-bit signed integer lanes |
| invalid_o | output | 2 | Per-lane invalid flag |
| inexact_o | output | 2 | Per-lane inexact flag |

## Verification
The bench keeps the default parameters: two lanes, 32-bit integers and a 16-bit narrow width. With these values the whole interesting exponent range is only a few dozen steps wide. The bench therefore sweeps every single-precision exponent from far below one up past 2^32, plus the zero, subnormal and all-ones exponent codes, combined with eight mantissa patterns and both signs, under every mode, truncate and rounding setting. A similar double-precision sweep reaches values just below and just above 2^31, where a half-way tie can round a lane into overflow. An independent real-number model supplies the expected values.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

  localparam int SP_W    = 32;
  localparam int SP_EW   = 8;
  localparam int SP_MW   = 23;
  localparam int SP_BIAS = (1 << (SP_EW - 1)) - 1;
  localparam int DP_W    = 64;
  localparam int DP_EW   = 11;
  localparam int DP_MW   = 52;
  localparam int DP_BIAS = (1 << (DP_EW - 1)) - 1;
  localparam int SIG_W   = DP_MW + 1;
  localparam int EXP_W   = DP_EW + 2;

  typedef enum logic [1:0] {
    MODE_STD_S    = 2'd0,
    MODE_RELAX_S  = 2'd1,
    MODE_NARROW_S = 2'd2,
    MODE_STD_D    = 2'd3
  } conv_mode_e;

  typedef enum logic [1:0] {
    RC_NEAR = 2'd0,
    RC_DOWN = 2'd1,
    RC_UP   = 2'd2,
    RC_ZERO = 2'd3
  } rnd_mode_e;

  // Common unpacked operand: value = sig (1.52 fixed point) * 2^exp
  typedef struct packed {
    logic                    sign;
    logic                    spec;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unp_t;

  function automatic unp_t unpack_sp(input logic [SP_W-1:0] w);
    unp_t u;
    logic [SP_EW-1:0] ef;
    logic [SP_MW-1:0] mf;
    ef = w[SP_W-2:SP_MW];
    mf = w[SP_MW-1:0];
    u.sign = w[SP_W-1];
    u.spec = &ef;
    if (ef == '0) u.exp = EXP_W'(1 - SP_BIAS);
    else          u.exp = EXP_W'(int'(ef) - SP_BIAS);
    u.sig = {(ef != '0), mf, {(SIG_W-1-SP_MW){1'b0}}};
    return u;
  endfunction

  function automatic unp_t unpack_dp(input logic [DP_W-1:0] w);
    unp_t u;
    logic [DP_EW-1:0] ef;
    ef = w[DP_W-2:DP_MW];
    u.sign = w[DP_W-1];
    u.spec = &ef;
    if (ef == '0) u.exp = EXP_W'(1 - DP_BIAS);
    else          u.exp = EXP_W'(int'(ef) - DP_BIAS);
    u.sig = {(ef != '0), w[DP_MW-1:0]};
    return u;
  endfunction

  // Increment decision from the kept lsb, the first dropped bit and the rest
  function automatic logic round_up(input rnd_mode_e rm, input logic sign,
                                    input logic lsb, input logic rbit,
                                    input logic sticky);
    logic r;
    case (rm)
      RC_NEAR: r = rbit & (sticky | lsb);
      RC_DOWN: r = sign & (rbit | sticky);
      RC_UP:   r = ~sign & (rbit | sticky);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import pfi_pkg::*;
(
  input  logic            use_dp,
  input  logic [SP_W-1:0] sp_word,
  input  logic [DP_W-1:0] dp_word,
  output unp_t            op
);

  assign op = use_dp ? unpack_dp(dp_word) : unpack_sp(sp_word);

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import pfi_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  unp_t             op,
  input  rnd_mode_e        rm,
  output logic [INT_W:0]   mag,
  output logic             too_big,
  output logic             lost,
  output logic             inc
);

  localparam int FRAC_POS   = 2 * INT_W;
  localparam int FIX_W      = FRAC_POS + INT_W;
  localparam int SHIFT_BASE = FRAC_POS - (SIG_W - 1);
  localparam int SH_W       = $clog2(FIX_W);

  int               e_i;
  logic [FIX_W-1:0] fix;
  logic [SH_W-1:0]  sh;
  logic [INT_W-1:0] ipart;
  logic             rbit;
  logic             sticky;

  always_comb begin
    e_i     = int'($signed(op.exp));
    sh      = '0;
    fix     = '0;
    ipart   = '0;
    rbit    = 1'b0;
    sticky  = 1'b0;
    too_big = 1'b0;
    if (e_i >= INT_W) begin
      too_big = 1'b1;
    end else if (e_i >= -SHIFT_BASE) begin
      sh     = SH_W'(e_i + SHIFT_BASE);
      fix    = {{(FIX_W-SIG_W){1'b0}}, op.sig} << sh;
      ipart  = fix[FIX_W-1:FRAC_POS];
      rbit   = fix[FRAC_POS-1];
      sticky = |fix[FRAC_POS-2:0];
    end else begin
      sticky = |op.sig;
    end
  end

  assign lost = rbit | sticky;
  assign inc  = round_up(rm, op.sign, ipart[0], rbit, sticky);
  assign mag  = {1'b0, ipart} + {{INT_W{1'b0}}, inc};

endmodule

// File: rtl/f2i_range.sv
module f2i_range
  import pfi_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int NAR_W = 16
) (
  input  conv_mode_e       mode,
  input  logic             sign,
  input  logic             spec,
  input  logic             too_big,
  input  logic [INT_W:0]   mag,
  input  logic             lost,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx
);

  localparam logic [INT_W:0]   POS_LIM   = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM   = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0]   POS_LIM_N = {{(INT_W-NAR_W+2){1'b0}}, {(NAR_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM_N = {{(INT_W-NAR_W+1){1'b0}}, 1'b1, {(NAR_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MIN_INT   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] SAT_P     = {{(INT_W-NAR_W+1){1'b0}}, {(NAR_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_N     = {{(INT_W-NAR_W+1){1'b1}}, {(NAR_W-1){1'b0}}};

  logic             std_mode;
  logic             ovf_wide;
  logic             ovf_narrow;
  logic [INT_W-1:0] signed_val;

  assign std_mode   = (mode == MODE_STD_S) || (mode == MODE_STD_D);
  assign ovf_wide   = too_big || (sign ? (mag > NEG_LIM)   : (mag > POS_LIM));
  assign ovf_narrow = too_big || (sign ? (mag > NEG_LIM_N) : (mag > POS_LIM_N));
  assign signed_val = sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];

  always_comb begin
    if (mode == MODE_NARROW_S) begin
      if (ovf_narrow) res = sign ? SAT_N : SAT_P;
      else            res = signed_val;
    end else if (spec || ovf_wide) begin
      res = MIN_INT;
    end else begin
      res = signed_val;
    end
  end

  assign inv = std_mode & (spec | ovf_wide);
  assign inx = std_mode & ~inv & lost;

endmodule

// File: rtl/pfi_conv.sv
module pfi_conv
  import pfi_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INT_W = 32,
  parameter int NAR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic                     trunc_i,
  input  logic [1:0]               rc_i,
  input  logic [LANES*SP_W-1:0]    src_lo_i,
  input  logic [LANES*SP_W-1:0]    src_hi_i,
  output logic [LANES*INT_W-1:0]   result_o,
  output logic [LANES-1:0]         invalid_o,
  output logic [LANES-1:0]         inexact_o
);

  localparam int DP_ALL = LANES * DP_W;

  conv_mode_e                   mode;
  logic                         std_mode;
  rnd_mode_e                    rm_eff;
  logic [DP_ALL-1:0]            dp_all;
  logic [LANES-1:0]             lane_inc;
  logic [LANES-1:0][INT_W-1:0]  res_c;
  logic [LANES-1:0]             inv_c;
  logic [LANES-1:0]             inx_c;

  assign mode     = conv_mode_e'(mode_i);
  assign std_mode = (mode == MODE_STD_S) || (mode == MODE_STD_D);
  assign rm_eff   = (std_mode && !trunc_i) ? rnd_mode_e'(rc_i) : RC_ZERO;
  assign dp_all   = {src_hi_i, src_lo_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    unp_t           op;
    logic [INT_W:0] mag;
    logic           too_big;
    logic           lost;

    f2i_unpack u_unp (
      .use_dp  (mode == MODE_STD_D),
      .sp_word (src_lo_i[g*SP_W +: SP_W]),
      .dp_word (dp_all[g*DP_W +: DP_W]),
      .op      (op)
    );

    f2i_round #(.INT_W(INT_W)) u_rnd (
      .op      (op),
      .rm      (rm_eff),
      .mag     (mag),
      .too_big (too_big),
      .lost    (lost),
      .inc     (lane_inc[g])
    );

    f2i_range #(.INT_W(INT_W), .NAR_W(NAR_W)) u_rng (
      .mode    (mode),
      .sign    (op.sign),
      .spec    (op.spec),
      .too_big (too_big),
      .mag     (mag),
      .lost    (lost),
      .res     (res_c[g]),
      .inv     (inv_c[g]),
      .inx     (inx_c[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      invalid_o <= '0;
      inexact_o <= '0;
    end else begin
      result_o  <= res_c;
      invalid_o <= inv_c;
      inexact_o <= inx_c;
    end
  end

endmodule

// File: rtl/pfi_checks.sv
module pfi_checks
  import pfi_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INT_W = 32,
  parameter int NAR_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             mode_i,
  input logic                   trunc_i,
  input rnd_mode_e              rm_eff,
  input logic [LANES-1:0]       lane_inc,
  input logic [LANES*INT_W-1:0] result_o,
  input logic [LANES-1:0]       invalid_o,
  input logic [LANES-1:0]       inexact_o
);

  // R10: relaxed and narrow modes never raise a flag
  p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RELAX_S || mode_i == MODE_NARROW_S) |=>
      (invalid_o == '0 && inexact_o == '0));

  // R3: a forced truncation never lets a lane increment
  p_trunc_no_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_i |-> (lane_inc == '0));

  // R3: toward-zero rounding never increments, whatever selected it
  p_zero_no_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_eff == RC_ZERO) |-> (lane_inc == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4: an invalid lane always carries the integer indefinite code
    p_invalid_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o[g] |-> (result_o[g*INT_W +: INT_W] == {1'b1, {(INT_W-1){1'b0}}}));

    // R5: inexact and invalid are exclusive on a lane
    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(invalid_o[g] && inexact_o[g]));

    // R8: narrow results are sign extensions of a 16-bit value
    p_narrow_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_NARROW_S) |=>
        ((&result_o[g*INT_W+NAR_W-1 +: INT_W-NAR_W+1]) ||
         !(|result_o[g*INT_W+NAR_W-1 +: INT_W-NAR_W+1])));
  end

endmodule

bind pfi_conv pfi_checks #(.LANES(LANES), .INT_W(INT_W), .NAR_W(NAR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .trunc_i   (trunc_i),
  .rm_eff    (rm_eff),
  .lane_inc  (lane_inc),
  .result_o  (result_o),
  .invalid_o (invalid_o),
  .inexact_o (inexact_o)
);

// File: tb/sim_pfi_conv.sv
module sim_pfi_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        trunc_i = 1'b0;
  logic [1:0]  rc_i = '0;
  logic [63:0] src_lo_i = '0;
  logic [63:0] src_hi_i = '0;
  logic [63:0] result_o;
  logic [1:0]  invalid_o;
  logic [1:0]  inexact_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pfi_conv u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trunc_i(trunc_i), .rc_i(rc_i),
    .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .result_o(result_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  function automatic real pow2(input int k);
    real p = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
    else        for (int i = 0; i < -k; i++) p = p / 2.0;
    return p;
  endfunction

  function automatic real sp_real(input logic [31:0] w);
    real v;
    int  ef = int'(w[30:23]);
    real mm = real'(w[22:0]);
    if (ef == 0) v = mm * pow2(-149);
    else         v = (8388608.0 + mm) * pow2(ef - 150);
    return w[31] ? -v : v;
  endfunction

  function automatic logic [31:0] sp_pat(input int k);
    logic [22:0] m;
    logic [7:0]  e;
    int ei = k / 16;
    case ((k / 2) % 8)
      0: m = 23'h000000;  1: m = 23'h400000;  2: m = 23'h200000;  3: m = 23'h600000;
      4: m = 23'h000001;  5: m = 23'h7FFFFF;  6: m = 23'h555555;  default: m = 23'h3FFFFF;
    endcase
    if (ei == 0)       e = 8'd0;
    else if (ei == 66) e = 8'd255;
    else               e = 8'(95 + ei);
    return {(k % 2 == 1), e, m};
  endfunction

  function automatic logic [63:0] dp_pat(input int k);
    logic [51:0] m;
    logic [10:0] e;
    int ei = k / 16;
    case ((k / 2) % 8)
      0: m = 52'h0;             1: m = 52'h8000000000000; 2: m = 52'h4000000000000;
      3: m = 52'hC000000000000; 4: m = 52'h1;             5: m = 52'hFFFFFFFFFFFFF;
      6: m = 52'h5555555555555; default: m = 52'h7FFFFFFFFFFFF;
    endcase
    if (ei == 0)       e = 11'd0;
    else if (ei == 49) e = 11'd2047;
    else               e = 11'(1013 + ei);
    return {(k % 2 == 1), e, m};
  endfunction

  // Expected lane value from the requirements, using real arithmetic
  task automatic model(input real x, input bit spec, input bit dnm, input logic [1:0] md,
                       input bit tr, input logic [1:0] rc, output logic [31:0] r,
                       output logic inv, output logic inx, output bit care);
    real t, f, d;
    care = 1'b1; inv = 1'b0; inx = 1'b0; r = '0;
    if (md == 2'd1 || md == 2'd2) begin
      care = !(spec || dnm);
      t = (x < 0.0) ? $ceil(x) : $floor(x);
      if (md == 2'd2) begin
        if (t > 32767.0)        r = 32'h00007FFF;
        else if (t < -32768.0)  r = 32'hFFFF8000;
        else                    r = 32'(longint'(t));
      end else begin
        if (t > 2147483647.0 || t < -2147483648.0) r = 32'h80000000;
        else                                       r = 32'(longint'(t));
      end
      return;
    end
    if (spec) begin r = 32'h80000000; inv = 1'b1; return; end
    f = $floor(x);
    d = x - f;
    if (tr || rc == 2'd3) t = (x < 0.0) ? $ceil(x) : f;
    else if (rc == 2'd1)  t = f;
    else if (rc == 2'd2)  t = $ceil(x);
    else if (d > 0.5)     t = f + 1.0;
    else if (d < 0.5)     t = f;
    else                  t = ((longint'(f) % 2) == 0) ? f : f + 1.0;
    if (t > 2147483647.0 || t < -2147483648.0) begin
      r = 32'h80000000; inv = 1'b1;
    end else begin
      r = 32'(longint'(t)); inx = (f != x);
    end
  endtask

  task automatic run_vec(input logic [1:0] md, input bit tr, input logic [1:0] rc,
                         input logic [63:0] lo, input logic [63:0] hi);
    @(negedge clk);
    mode_i = md; trunc_i = tr; rc_i = rc; src_lo_i = lo; src_hi_i = hi;
    @(negedge clk);
    for (int ln = 0; ln < 2; ln++) begin
      logic [63:0] dw;
      logic [31:0] sw, er, ar;
      real         x;
      bit          spec, dnm, care;
      logic        ei, ex;
      string       tag;
      if (md == 2'd3) begin
        dw   = (ln == 1) ? hi : lo;
        x    = $bitstoreal(dw);
        spec = (dw[62:52] == 11'h7FF);
        dnm  = (dw[62:52] == 11'h0) && (dw[51:0] != 52'h0);
      end else begin
        sw   = lo[ln*32 +: 32];
        x    = sp_real(sw);
        spec = (sw[30:23] == 8'hFF);
        dnm  = (sw[30:23] == 8'h0) && (sw[22:0] != 23'h0);
      end
      model(x, spec, dnm, md, tr, rc, er, ei, ex, care);
      ar = result_o[ln*32 +: 32];
      if (md == 2'd1 || md == 2'd2)
        tag = (invalid_o[ln] || inexact_o[ln]) ? "R10" : ((md == 2'd2) ? "R8" : "R9");
      else if (ei)                  tag = "R4";
      else if (dnm)                 tag = "R6";
      else if (inexact_o[ln] !== ex) tag = "R5";
      else if (md == 2'd3)          tag = "R7";
      else if (tr)                  tag = "R3";
      else                          tag = "R2";
      n_checks++;
      if ((care && ar !== er) || invalid_o[ln] !== ei || inexact_o[ln] !== ex) begin
        n_fail++;
        $display("FAIL %s lane%0d mode=%0d trunc=%0b rc=%0d: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                 tag, ln, md, tr, rc, ar, invalid_o[ln], inexact_o[ln], er, ei, ex);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (result_o !== 64'h0 || invalid_o !== 2'b0 || inexact_o !== 2'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h inv=%b inx=%b, expected 0 inv=00 inx=00",
               result_o, invalid_o, inexact_o);
    end
    rst_n = 1'b1;

    // Directed edge cases: +-2^31, +-0.5 ties, negative zero, largest below 2^31
    for (int rc = 0; rc < 4; rc++) begin
      run_vec(2'd0, 1'b0, 2'(rc), {32'hCF000000, 32'h4F000000}, 64'hFFFF_FFFF_FFFF_FFFF);
      run_vec(2'd0, 1'b0, 2'(rc), {32'hBF000000, 32'h3F000000}, 64'h0);
      run_vec(2'd0, 1'b0, 2'(rc), {32'h80000000, 32'h4EFFFFFF}, 64'h0);
      run_vec(2'd0, 1'b0, 2'(rc), {32'hC0200000, 32'h3FC00000}, 64'h0);
      run_vec(2'd3, 1'b0, 2'(rc), 64'h41DFFFFFFFE00000, 64'hC1E0000000100000);
      run_vec(2'd3, 1'b1, 2'(rc), 64'h41DFFFFFFFE00000, 64'hC1E0000000100000);
    end
    // Narrow 16-bit boundaries: 32767.5, 32768, -32768, -32769
    run_vec(2'd2, 1'b0, 2'd0, {32'h47000000, 32'h46FFFF00}, 64'h0);
    run_vec(2'd2, 1'b1, 2'd2, {32'hC7000100, 32'hC7000000}, 64'h0);

    // Single-precision sweep over modes 0..2, every truncate and rounding setting
    for (int md = 0; md < 3; md++)
      for (int tr = 0; tr < 2; tr++)
        for (int rc = 0; rc < 4; rc++)
          for (int j = 0; j < 536; j++)
            run_vec(2'(md), tr[0], 2'(rc), {sp_pat(2*j+1), sp_pat(2*j)},
                    ~{sp_pat(2*j), sp_pat(2*j+1)});

    // Double-precision sweep
    for (int tr = 0; tr < 2; tr++)
      for (int rc = 0; rc < 4; rc++)
        for (int j = 0; j < 400; j++)
          run_vec(2'd3, tr[0], 2'(rc), dp_pat(2*j), dp_pat(2*j+1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule